// File: doc/BRIEF.md
# Incremental Pane Aggregate Unit

This block keeps the running aggregates of one pane of a sliding-window query. A window controller drives two control lines. One says that the sample on the data input belongs to the current pane. The other says that the pane has ended. Each cycle in which the first line is high, the block folds the sample into four running values: a count of accepted samples, their sum, their minimum and their maximum. Only these four partial results are held. No sample is stored.

When the controller signals that the pane has ended, the block copies the finished aggregates into output registers and pulses a result-valid strobe for one cycle. It then restarts all four values from their empty state, so the next pane begins clean. A parameterised output mux presents one of the aggregates on a selected-result port. Its default choice is the count. The block makes no windowing decisions and does not merge results across pane instances.

Top module: `pane_fold_unit`

## Requirements
- R1: After a synchronous reset, `res_valid` is 0, `res_count`, `res_sum` and `res_sel` are 0, `res_min` holds the largest signed value of DATA_W bits and `res_max` holds the smallest.
- R2: At a pane close, `res_count` reports how many cycles had `fold_en` high (and `pane_close` low) since the previous close or reset.
- R3: At a pane close, `res_sum` reports the two's-complement sum of the signed samples folded in that pane, modulo 2^SUM_W, where SUM_W = DATA_W + CNT_W.
- R4: At a pane close, `res_min` reports the smallest signed sample folded in that pane. An empty pane reports the largest signed DATA_W value.
- R5: At a pane close, `res_max` reports the largest signed sample folded in that pane. An empty pane reports the smallest signed DATA_W value.
- R6: A cycle with `fold_en` low and `pane_close` low changes no aggregate, whatever `sample` holds.
- R7: A cycle with `pane_close` high makes `res_valid` 1 in the following cycle and loads the result ports. In a cycle after one without `pane_close`, `res_valid` is 0 and every result port keeps its value.
- R8: The cycle after a close, the running aggregates are back in their empty state, so the next pane's results exclude every earlier sample.
- R9: When `fold_en` and `pane_close` are high together, the close wins and that cycle's sample is folded into neither pane.
- R10: With the default mux choice, `res_sel` equals `res_count` zero-extended to SUM_W bits.
- R11: The count wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fold_en | input | 1 | Sample belongs to the current pane |
| pane_close | input | 1 | Current pane ends this cycle |
| sample | input | DATA_W | Signed data value |
| res_valid | output | 1 | One-cycle strobe, results valid |
| res_sel | output | SUM_W | Mux-selected result (count by default) |
| res_count | output | CNT_W | Samples in the finished pane |
| res_sum | output | SUM_W | Signed sum of the finished pane |
| res_min | output | DATA_W | Signed minimum of the finished pane |
| res_max | output | DATA_W | Signed maximum of the finished pane |

## Verification
The bench builds the block with DATA_W = 8 and CNT_W = 6, which gives a 14-bit sum. With these values, the signed extremes of -128 and 127 can be driven directly. A pane of 70 samples wraps the count past 63, and the same pane pushes the sum beyond the 14-bit signed range, so the modulo behaviour of both values is exercised. The random phase mixes folds, idle cycles, coincident fold-and-close cycles and back-to-back closes.

// File: rtl/pane_fold_pkg.sv
package pane_fold_pkg;

    // Per-cycle action on the running aggregates
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_FOLD  = 2'd1,
        ACT_CLOSE = 2'd2
    } pane_act_e;

    // Aggregate presented on the selected-result port
    typedef enum logic [1:0] {
        AGG_COUNT = 2'd0,
        AGG_SUM   = 2'd1,
        AGG_MIN   = 2'd2,
        AGG_MAX   = 2'd3
    } agg_kind_e;

    // Close has priority over fold
    function automatic pane_act_e decode_act(input logic take, input logic close);
        if (close)
            return ACT_CLOSE;
        else if (take)
            return ACT_FOLD;
        else
            return ACT_HOLD;
    endfunction

endpackage

// File: rtl/pane_sum_lane.sv
module pane_sum_lane
    import pane_fold_pkg::*;
#(
    parameter int W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  pane_act_e       act,
    input  logic [W-1:0]    addend,
    output logic [W-1:0]    acc
);

    always_ff @(posedge clk) begin
        if (rst || act == ACT_CLOSE)
            acc <= '0;
        else if (act == ACT_FOLD)
            acc <= acc + addend;
    end

    // R6
    hold_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
        act == ACT_HOLD |=> $stable(acc));

    // R8
    close_empties_acc_chk: assert property (@(posedge clk) disable iff (rst)
        act == ACT_CLOSE |=> acc == '0);

endmodule

// File: rtl/pane_extreme_lane.sv
module pane_extreme_lane
    import pane_fold_pkg::*;
#(
    parameter int W        = 16,
    parameter bit TAKE_MIN = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  pane_act_e       act,
    input  logic [W-1:0]    din,
    output logic [W-1:0]    acc
);

    localparam logic [W-1:0] POS_LIMIT = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] SEED      = TAKE_MIN ? POS_LIMIT : NEG_LIMIT;

    logic better;

    generate
        if (TAKE_MIN) begin : g_min
            always_comb better = $signed(din) < $signed(acc);
        end else begin : g_max
            always_comb better = $signed(din) > $signed(acc);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || act == ACT_CLOSE)
            acc <= SEED;
        else if (act == ACT_FOLD && better)
            acc <= din;
    end

    // R4 R5
    fold_bounds_sample_chk: assert property (@(posedge clk) disable iff (rst)
        act == ACT_FOLD |=> (TAKE_MIN ? ($signed(acc) <= $signed($past(din)))
                                      : ($signed(acc) >= $signed($past(din)))));

    // R8
    close_reseeds_chk: assert property (@(posedge clk) disable iff (rst)
        act == ACT_CLOSE |=> acc == SEED);

endmodule

// File: rtl/pane_fold_unit.sv
module pane_fold_unit
    import pane_fold_pkg::*;
#(
    parameter int        DATA_W   = 16,
    parameter int        CNT_W    = 16,
    parameter agg_kind_e OUT_KIND = AGG_COUNT,
    localparam int       SUM_W    = DATA_W + CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fold_en,
    input  logic              pane_close,
    input  logic [DATA_W-1:0] sample,
    output logic              res_valid,
    output logic [SUM_W-1:0]  res_sel,
    output logic [CNT_W-1:0]  res_count,
    output logic [SUM_W-1:0]  res_sum,
    output logic [DATA_W-1:0] res_min,
    output logic [DATA_W-1:0] res_max
);

    localparam logic [DATA_W-1:0] POS_LIMIT = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_LIMIT = {1'b1, {(DATA_W-1){1'b0}}};

    pane_act_e         act;
    logic [CNT_W-1:0]  run_cnt;
    logic [SUM_W-1:0]  run_sum;
    logic [DATA_W-1:0] run_min;
    logic [DATA_W-1:0] run_max;
    logic [SUM_W-1:0]  sample_ext;
    logic [SUM_W-1:0]  sel_next;

    always_comb act = decode_act(fold_en, pane_close);
    always_comb sample_ext = {{CNT_W{sample[DATA_W-1]}}, sample};

    pane_sum_lane #(.W(CNT_W)) u_count (
        .clk(clk), .rst(rst), .act(act),
        .addend(CNT_W'(1)), .acc(run_cnt)
    );

    pane_sum_lane #(.W(SUM_W)) u_sum (
        .clk(clk), .rst(rst), .act(act),
        .addend(sample_ext), .acc(run_sum)
    );

    pane_extreme_lane #(.W(DATA_W), .TAKE_MIN(1'b1)) u_min (
        .clk(clk), .rst(rst), .act(act),
        .din(sample), .acc(run_min)
    );

    pane_extreme_lane #(.W(DATA_W), .TAKE_MIN(1'b0)) u_max (
        .clk(clk), .rst(rst), .act(act),
        .din(sample), .acc(run_max)
    );

    // Result mux: a fixed choice made by parameter
    always_comb begin
        case (OUT_KIND)
            AGG_COUNT: sel_next = SUM_W'(run_cnt);
            AGG_SUM:   sel_next = run_sum;
            AGG_MIN:   sel_next = {{CNT_W{run_min[DATA_W-1]}}, run_min};
            default:   sel_next = {{CNT_W{run_max[DATA_W-1]}}, run_max};
        endcase
    end

    // Result registers load the finished pane while the lanes clear
    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_sel   <= '0;
            res_count <= '0;
            res_sum   <= '0;
            res_min   <= POS_LIMIT;
            res_max   <= NEG_LIMIT;
        end else begin
            res_valid <= (act == ACT_CLOSE);
            if (act == ACT_CLOSE) begin
                res_sel   <= sel_next;
                res_count <= run_cnt;
                res_sum   <= run_sum;
                res_min   <= run_min;
                res_max   <= run_max;
            end
        end
    end

    // R7
    close_strobes_chk: assert property (@(posedge clk) disable iff (rst)
        pane_close |=> res_valid);

    // R7
    no_close_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !pane_close |=> !res_valid);

    // R7
    results_held_chk: assert property (@(posedge clk) disable iff (rst)
        !pane_close |=> $stable(res_count) && $stable(res_sum)
                        && $stable(res_min) && $stable(res_max));

    // R9
    close_beats_fold_chk: assert property (@(posedge clk) disable iff (rst)
        pane_close && fold_en |=> run_cnt == '0);

    generate
        if (OUT_KIND == AGG_COUNT) begin : g_sel_count
            // R10
            sel_is_count_chk: assert property (@(posedge clk) disable iff (rst)
                res_valid |-> res_sel == SUM_W'(res_count));
        end
    endgenerate

endmodule

// File: tb/pane_fold_unit_bench.sv
module pane_fold_unit_bench;
    import pane_fold_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int CW = 6;
    localparam int SW = DW + CW;

    logic          clk = 1'b0;
    logic          rst;
    logic          fold_en;
    logic          pane_close;
    logic [DW-1:0] sample;
    logic          res_valid;
    logic [SW-1:0] res_sel;
    logic [CW-1:0] res_count;
    logic [SW-1:0] res_sum;
    logic [DW-1:0] res_min;
    logic [DW-1:0] res_max;

    always #(CLK_PERIOD/2) clk = ~clk;

    pane_fold_unit #(.DATA_W(DW), .CNT_W(CW)) u_pane_fold_unit (
        .clk(clk), .rst(rst), .fold_en(fold_en), .pane_close(pane_close),
        .sample(sample), .res_valid(res_valid), .res_sel(res_sel),
        .res_count(res_count), .res_sum(res_sum), .res_min(res_min),
        .res_max(res_max)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model of the running pane
    int m_cnt, m_sum, m_min, m_max;
    // Last results the outputs should show
    int e_cnt = 0, e_sum = 0, e_min = 127, e_max = -128;
    bit e_valid = 1'b0;
    string e_tag = "R1";

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic void model_clear();
        m_cnt = 0; m_sum = 0; m_min = 127; m_max = -128;
    endfunction

    function automatic int wrap_cnt(input int c);
        return c % (1 << CW);
    endfunction

    function automatic int wrap_sum(input int s);
        return s & ((1 << SW) - 1);
    endfunction

    // Checks the outputs produced by the previous step, then drives a new one
    task automatic step(input bit f, input bit c, input int v, input string tag);
        @(negedge clk);
        chk(res_valid == e_valid, {e_tag, "/R7 valid"}, int'(res_valid), int'(e_valid));
        chk(int'(res_count) == e_cnt, {e_tag, "/R2 count"}, int'(res_count), e_cnt);
        chk(int'(res_sum) == e_sum, {e_tag, "/R3 sum"}, int'(res_sum), e_sum);
        chk(int'($signed(res_min)) == e_min, {e_tag, "/R4 min"}, int'($signed(res_min)), e_min);
        chk(int'($signed(res_max)) == e_max, {e_tag, "/R5 max"}, int'($signed(res_max)), e_max);
        // R10: selected result tracks the count
        chk(int'(res_sel) == int'(res_count), {e_tag, "/R10 sel"}, int'(res_sel), int'(res_count));
        fold_en    = f;
        pane_close = c;
        sample     = DW'(v);
        e_valid    = c;
        e_tag      = tag;
        if (c) begin
            // R9: close wins, sample not folded
            e_cnt = wrap_cnt(m_cnt);
            e_sum = wrap_sum(m_sum);
            e_min = m_min;
            e_max = m_max;
            model_clear();
        end else if (f) begin
            m_cnt++;
            m_sum += v;
            if (v < m_min) m_min = v;
            if (v > m_max) m_max = v;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; fold_en = 1'b0; pane_close = 1'b0; sample = '0;
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset values seen by the first check
        step(0, 0, 0, "R1");
        // R8: empty pane close
        step(0, 1, 0, "R8");
        step(0, 0, 0, "R8");

        // R6: idle cycles with noisy samples are ignored
        step(1, 0, 5, "R2");
        step(1, 0, -3, "R6");
        step(0, 0, -128, "R6");
        step(1, 0, 100, "R6");
        step(0, 0, 127, "R6");
        step(1, 0, 7, "R6");
        step(0, 1, 0, "R6");
        step(0, 0, 0, "R6");

        // R9: coincident fold and close
        step(1, 0, 20, "R9");
        step(1, 1, -100, "R9");
        step(1, 0, 1, "R9");
        step(0, 1, 0, "R9");
        step(0, 0, 0, "R9");

        // R4 R5: signed extremes
        step(1, 0, 127, "R5");
        step(1, 0, -128, "R4");
        step(0, 1, 0, "R4");
        step(0, 0, 0, "R5");

        // R11: count wrap and sum modulo
        for (int i = 0; i < 70; i++) step(1, 0, 127, "R11");
        step(0, 1, 0, "R11");
        step(0, 0, 0, "R11");

        // R7: back-to-back closes
        step(1, 0, -9, "R7");
        step(0, 1, 0, "R7");
        step(0, 1, 0, "R7");
        step(0, 0, 0, "R7");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            bit f = ($urandom % 3) != 0;
            bit c = ($urandom % 10) == 0;
            int v = int'($urandom % 256) - 128;
            step(f, c, v, "R3");
        end
        step(0, 1, 0, "R3");
        step(0, 0, 0, "R3");
        step(0, 0, 0, "R3");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule